// File: doc/BRIEF.md
# Keyed-Write Memory Controller Configuration Bank

This block holds the configuration words of an external-memory bus controller. It has seven 16-bit registers: two bus setup words, a wait-timing word, a memory-type word, and the status, count and constant words of the refresh timer. A simple memory-mapped port reads and writes them, and each request is answered one clock later.

Registers can change only through a 32-bit write whose upper halfword carries the fixed key 0xA55A. The bank then stores the lower halfword. Any other write is discarded, and a one-cycle reject pulse reports the discard. A 16-bit access reads the same register at an address 2 above its 32-bit address. A 16-bit write is refused.

Reads always return a zero-extended value. Addresses that map to no register read as zero and cannot be written. What the bits mean and how the refresh counter counts are left to the logic that consumes the register outputs.

Top module: `keyed_reg_bank`

## Requirements
- R1: After a synchronous active-high reset, the registers read 0x03F0, 0x00FC, 0xAAFF, 0x0000, 0x0000, 0x0000 and 0x0000, in the order of their 32-bit addresses 0xFFFFFFE0, E4, E8, EC, F0, F4 and F8.
- R2: A 32-bit read (`req_wide`=1, `req_we`=0) at the address of register i returns that register in bits 15:0 and zero in bits 31:16.
- R3: A 32-bit write at the address of a register stores write-data bits 15:0 when write-data bits 31:16 equal 0xA55A. The new value is visible to the next request, and `wr_reject` stays low.
- R4: A 32-bit write with any other value in bits 31:16 changes no register and raises `wr_reject` for one cycle.
- R5: A 16-bit read (`req_wide`=0) at the 32-bit address plus 2 returns the same register, zero-extended to 32 bits.
- R6: A 16-bit write changes no register, even when it carries the key, and raises `wr_reject`.
- R7: An access to any other address, including 32-bit accesses at +2 and 16-bit accesses at +0 or at odd offsets, reads as zero. A write to such an address changes nothing and raises `wr_reject`.
- R8: `rsp_ready` is high in exactly the cycle after each request, and read data and `wr_reject` are valid in that cycle.
- R9: Asserting reset after registers have been written brings every register back to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data; the key is in bits 31:16 |
| rsp_ready | output | 1 | Response valid, one cycle after a request |
| rsp_rdata | output | 32 | Zero-extended read data; zero for writes |
| wr_reject | output | 1 | One-cycle pulse for a discarded write |

## Verification
The bench sweeps every byte address in the 32-byte window above the base, plus addresses outside it, with both access sizes. This separates the seven real slots from the +2 aliases and from the misaligned and unmapped holes. Writes are tried with the correct key and with keys that differ from it in one bit, in mirrored halves, and in all bits. A keyed write is also sent down the 16-bit path. Each write is followed by reads at both sizes, so a stored value, a refused value, and a write landing in the wrong slot can all be told apart. A reset issued after the registers have been written shows that every value returns to its reset value.

// File: rtl/keyed_reg_bank_pkg.sv
package keyed_reg_bank_pkg;

    localparam int unsigned HALF_W = 16;
    localparam logic [HALF_W-1:0] WRITE_KEY = 16'hA55A;

    // Power-on contents, indexed by register slot.
    function automatic logic [HALF_W-1:0] init_word(input int unsigned slot);
        case (slot)
            0:       init_word = 16'h03F0;
            1:       init_word = 16'h00FC;
            2:       init_word = 16'hAAFF;
            default: init_word = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/keyed_reg_bank_decode.sv
module keyed_reg_bank_decode #(
    parameter int unsigned     NREG   = 7,
    parameter logic [31:0]     BASE   = 32'hFFFF_FFE0,
    localparam int unsigned    IDXW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [31:0]     addr,
    input  logic            wide,
    output logic            hit,
    output logic [IDXW-1:0] idx
);

    logic [NREG-1:0] match;

    // One comparator per slot: 32-bit view at +0, 16-bit view at +2.
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [31:0] WIDE_A   = BASE + 32'(4 * g);
        localparam logic [31:0] NARROW_A = BASE + 32'(4 * g + 2);
        assign match[g] = wide ? (addr == WIDE_A) : (addr == NARROW_A);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) idx = IDXW'(i);
        end
    end

endmodule

// File: rtl/keyed_reg_bank_keygate.sv
module keyed_reg_bank_keygate
    import keyed_reg_bank_pkg::*;
(
    input  logic              valid,
    input  logic              we,
    input  logic              wide,
    input  logic              hit,
    input  logic [HALF_W-1:0] key,
    output logic              accept,
    output logic              reject
);

    logic is_write;

    always_comb begin
        is_write = valid && we;
        accept   = is_write && wide && hit && (key == WRITE_KEY);
        reject   = is_write && !accept;
    end

endmodule

// File: rtl/keyed_reg_bank.sv
module keyed_reg_bank
    import keyed_reg_bank_pkg::*;
#(
    parameter int unsigned NREG = 7,
    parameter logic [31:0] BASE = 32'hFFFF_FFE0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_we,
    input  logic        req_wide,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_ready,
    output logic [31:0] rsp_rdata,
    output logic        wr_reject
);

    localparam int unsigned IDXW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned BUS_W = 2 * HALF_W;

    typedef struct packed {
        logic [NREG-1:0][HALF_W-1:0] regs;
        logic                        ready;
        logic [BUS_W-1:0]            rdata;
        logic                        rej;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic            dec_hit;
    logic [IDXW-1:0] dec_idx;
    logic            wr_accept;
    logic            wr_refuse;

    keyed_reg_bank_decode #(
        .NREG (NREG),
        .BASE (BASE)
    ) decode_i (
        .addr (req_addr),
        .wide (req_wide),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    keyed_reg_bank_keygate keygate_i (
        .valid  (req_valid),
        .we     (req_we),
        .wide   (req_wide),
        .hit    (dec_hit),
        .key    (req_wdata[BUS_W-1:HALF_W]),
        .accept (wr_accept),
        .reject (wr_refuse)
    );

    function automatic bank_state_t reset_state();
        bank_state_t s;
        s = '0;
        for (int i = 0; i < NREG; i++) s.regs[i] = init_word(i);
        return s;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.ready = req_valid;
        st_d.rej   = wr_refuse;
        st_d.rdata = '0;
        if (req_valid && !req_we && dec_hit) begin
            st_d.rdata = {{HALF_W{1'b0}}, st_q.regs[dec_idx]};
        end
        for (int i = 0; i < NREG; i++) begin
            if (wr_accept && dec_idx == IDXW'(i)) begin
                st_d.regs[i] = req_wdata[HALF_W-1:0];
            end
        end
        if (rst) st_d = reset_state();
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rsp_ready = st_q.ready;
    assign rsp_rdata = st_q.rdata;
    assign wr_reject = st_q.rej;

    // R8: a response follows every request, and only a request
    a_r8_ready_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ready);
    a_r8_no_spurious_ready: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_ready);
    // R2/R5: the upper halfword of the read data is always zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> rsp_rdata[BUS_W-1:HALF_W] == '0);
    // R4: a reject pulse follows only a write request
    a_r4_reject_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> $past(req_valid && req_we));
    // R6: a 16-bit write is always refused
    a_r6_narrow_write_refused: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_we && !req_wide) |=> wr_reject);
    // R3/R4: without an accepted write the register contents hold
    a_r3_hold_without_accept: assert property (@(posedge clk) disable iff (rst)
        (!wr_accept && !rst) |=> $stable(st_q.regs));
    // R7: an unmapped read returns zero
    a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && !dec_hit) |=> rsp_rdata == '0);

endmodule

// File: tb/keyed_reg_bank_tb_top.sv
module keyed_reg_bank_tb_top;

    localparam logic [31:0] BASE = 32'hFFFF_FFE0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic        req_wide = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic        wr_reject;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [15:0] mdl [7];

    always #2.5 clk = ~clk;

    keyed_reg_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata),
        .wr_reject (wr_reject)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] rv(input int s);
        case (s)
            0: rv = 16'h03F0;
            1: rv = 16'h00FC;
            2: rv = 16'hAAFF;
            default: rv = 16'h0000;
        endcase
    endfunction

    // Returns the slot (0..6) an access maps to, or -1.
    function automatic int slot_of(input logic [31:0] a, input logic wide);
        logic [31:0] off;
        off = a - BASE;
        if (a < BASE) return -1;
        if (off[31:2] > 6) return -1;
        if (wide && off[1:0] == 2'd0) return int'(off[4:2]);
        if (!wide && off[1:0] == 2'd2) return int'(off[4:2]);
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request and compare the response one cycle later.
    task automatic access(input string req, input logic we, input logic wide,
                          input logic [31:0] a, input logic [31:0] wd);
        int s;
        logic [31:0] exp_rd;
        logic exp_rej;
        s = slot_of(a, wide);
        exp_rd = (!we && s >= 0) ? {16'h0, mdl[s]} : 32'h0;
        exp_rej = we && !(wide && s >= 0 && wd[31:16] == 16'hA55A);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_wide = wide; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " ready"}, {31'h0, rsp_ready}, 32'h1);
        check({req, " rdata"}, rsp_rdata, exp_rd);
        check({req, " reject"}, {31'h0, wr_reject}, {31'h0, exp_rej});
        if (we && !exp_rej) mdl[s] = wd[15:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 7; i++) mdl[i] = rv(i);
    endtask

    initial begin
        logic [15:0] bad_keys [4];
        bad_keys[0] = 16'h0000; bad_keys[1] = 16'hA55B;
        bad_keys[2] = 16'h5AA5; bad_keys[3] = 16'hFFFF;
        do_reset();
        // R1: reset values through 32-bit reads, R5 through 16-bit reads
        for (int i = 0; i < 7; i++) begin
            access("R1 reset value", 1'b0, 1'b1, BASE + 32'(4 * i), '0);
            check("R1 exact value", {16'h0, mdl[i]}, {16'h0, rv(i)});
            access("R5 narrow reset read", 1'b0, 1'b0, BASE + 32'(4 * i + 2), '0);
        end
        // R8: no response without a request
        @(negedge clk);
        check("R8 idle ready", {31'h0, rsp_ready}, 32'h0);
        // R2/R5/R7: full address sweep at both sizes
        for (int o = 0; o < 32; o++) begin
            access("R2 R7 wide sweep", 1'b0, 1'b1, BASE + 32'(o), '0);
            access("R5 R7 narrow sweep", 1'b0, 1'b0, BASE + 32'(o), '0);
        end
        access("R7 far wide read", 1'b0, 1'b1, 32'h0000_0000, '0);
        access("R7 below base", 1'b0, 1'b1, BASE - 32'd4, '0);
        // R3: keyed writes to every slot, then read back at both sizes
        for (int i = 0; i < 7; i++) begin
            access("R3 keyed write", 1'b1, 1'b1, BASE + 32'(4 * i),
                   {16'hA55A, 16'h1234 ^ 16'(i * 16'h1111)});
        end
        for (int i = 0; i < 7; i++) begin
            access("R3 readback", 1'b0, 1'b1, BASE + 32'(4 * i), '0);
            access("R5 narrow readback", 1'b0, 1'b0, BASE + 32'(4 * i + 2), '0);
        end
        // R4: wrong keys
        for (int i = 0; i < 7; i++) begin
            for (int k = 0; k < 4; k++) begin
                access("R4 bad key write", 1'b1, 1'b1, BASE + 32'(4 * i),
                       {bad_keys[k], 16'hDEAD});
            end
            access("R4 unchanged", 1'b0, 1'b1, BASE + 32'(4 * i), '0);
        end
        // R6: 16-bit writes, even carrying the key
        for (int i = 0; i < 7; i++) begin
            access("R6 narrow write", 1'b1, 1'b0, BASE + 32'(4 * i + 2), {16'hA55A, 16'hBEEF});
            access("R6 narrow write +0", 1'b1, 1'b0, BASE + 32'(4 * i), {16'hA55A, 16'hBEEF});
            access("R6 unchanged", 1'b0, 1'b1, BASE + 32'(4 * i), '0);
        end
        // R7: keyed writes to holes and aliases
        for (int o = 1; o < 32; o++) begin
            if (o % 4 != 0 || o >= 28) begin
                access("R7 hole write", 1'b1, 1'b1, BASE + 32'(o), {16'hA55A, 16'h0F0F});
            end
        end
        for (int i = 0; i < 7; i++) begin
            access("R7 unchanged", 1'b0, 1'b1, BASE + 32'(4 * i), '0);
        end
        // R8: back-to-back requests, then idle
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_wide = 1'b1; req_addr = BASE + 32'd8;
        @(negedge clk);
        req_addr = BASE + 32'd4;
        check("R8 b2b ready 1", {31'h0, rsp_ready}, 32'h1);
        check("R8 b2b data 1", rsp_rdata, {16'h0, mdl[2]});
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 b2b ready 2", {31'h0, rsp_ready}, 32'h1);
        check("R8 b2b data 2", rsp_rdata, {16'h0, mdl[1]});
        @(negedge clk);
        check("R8 ready drops", {31'h0, rsp_ready}, 32'h0);
        // R9: reset after writes restores values
        do_reset();
        for (int i = 0; i < 7; i++) begin
            access("R9 reset restores", 1'b0, 1'b1, BASE + 32'(4 * i), '0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule